// File: doc/BRIEF.md
# Indirect Memory-Controller Register File

This block holds the 32-bit configuration and status registers of a memory controller. Software reaches them indirectly through two ports on a simple synchronous register bus. A write to the pointer port stores a register offset. A read or write of the window port then reaches the register at that offset. A read of the pointer port returns the stored offset.

Each register has its own write behaviour:
- Some registers keep only the bits allowed by a mask.
- One register forces a fixed field to ones.
- The two bus-error registers clear every bit that is written as one. Hardware sets their bits through two capture inputs.
- A read-only status register follows the edges of two config bits rather than their levels.

The ECC error status register drives a level interrupt. The global enable bit and the whole config word go out to the rest of the controller.

Read data is registered: it appears in the cycle after the read strobe and holds until the next read strobe. A write strobe and a read strobe never arrive in the same cycle.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A write to port 0x010 stores the full 32-bit offset, and a read of port 0x010 returns it. Port 0x011 reads or writes the register the stored offset selects.
- R2: `bus_rdata` takes its new value on the clock edge that samples `bus_rd` high. It then stays unchanged while `bus_rd` is low. `bus_wr` and `bus_rd` are never high in the same cycle.
- R3: The error registers at offsets 0x00 and 0x08 work as follows. A window write clears each bit written as one and keeps the other bits. A one on `err_set_a` (for 0x00) or `err_set_b` (for 0x08) sets that bit, and setting wins over clearing in the same cycle.
- R4: Offset 0x10 is a plain 32-bit read/write error-address register.
- R5: The config register at offset 0x20 stores write data ANDed with 0xFFE00000. `cfg_word` shows the stored config word, and `ctrl_enable` is its bit 31.
- R6: On a config write, bit 31 going from 0 to 1 clears status bit 31, and bit 31 going from 1 to 0 sets status bit 31.
- R7: On a config write, bit 30 going from 0 to 1 sets status bit 30, and bit 30 going from 1 to 0 clears status bit 30.
- R8: The status register at offset 0x24 is read-only, and window writes to it change nothing.
- R9: Stored values on write are as follows:
  - offset 0x30 (refresh): data AND 0x3FF80000
  - offset 0x94 (ECC config): data AND 0x00F00000
  - offset 0x34 (power management): (data AND 0xF8000000) OR 0x07C00000
- R10: The ECC error status register at offset 0x98 stores data AND 0xFFF0F000. `ecc_irq` is high exactly while the stored value is nonzero.
- R11: Window reads of the timing offset 0x80 and of any unmapped offset return 0xFFFFFFFF.
- R12: The reset values are:
  - offset register, error registers, error address, ECC config, ECC status and status: 0
  - power management: 0x07C00000
  - refresh: 0x05F00000
  - config: 0x00800000
- R13: A read of any port other than 0x010 and 0x011 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_port | input | PORT_W | Register-bus port number |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| err_set_a | input | DATA_W | Set pulses for error register at 0x00 |
| err_set_b | input | DATA_W | Set pulses for error register at 0x08 |
| bus_rdata | output | DATA_W | Registered read data |
| ctrl_enable | output | 1 | Global controller enable (config bit 31) |
| cfg_word | output | DATA_W | Stored config register |
| ecc_irq | output | 1 | Level interrupt, ECC error status nonzero |

## Verification
A table of offsets is each written with all ones, all zeros and mixed patterns, then read back. All-ones data shows whether each register keeps exactly its own mask. All-zeros data on the power-management register shows whether the forced field is present. Config writes are sequenced to drive bit 30 up, then both bits down, then bit 31 alone up, so the status readback tells apart edge tracking from level copying. Error registers are loaded through the set inputs and then partly cleared, including one cycle where a set and a clear hit the same bit, to separate write-one-to-clear from plain writes and to confirm that setting wins.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
   localparam int REG_W = 32;
   typedef logic [REG_W-1:0] word_t;

   // window offsets, fixed because software decodes them
   localparam word_t OFS_ERR_A  = 32'h00;
   localparam word_t OFS_ERR_B  = 32'h08;
   localparam word_t OFS_EADDR  = 32'h10;
   localparam word_t OFS_CFG    = 32'h20;
   localparam word_t OFS_STAT   = 32'h24;
   localparam word_t OFS_RFSH   = 32'h30;
   localparam word_t OFS_PWR    = 32'h34;
   localparam word_t OFS_TIMING = 32'h80;
   localparam word_t OFS_ECFG   = 32'h94;
   localparam word_t OFS_ESTAT  = 32'h98;

   localparam word_t MASK_CFG   = 32'hFFE0_0000;
   localparam word_t MASK_RFSH  = 32'h3FF8_0000;
   localparam word_t MASK_PWR   = 32'hF800_0000;
   localparam word_t FORCE_PWR  = 32'h07C0_0000;
   localparam word_t MASK_ECFG  = 32'h00F0_0000;
   localparam word_t MASK_ESTAT = 32'hFFF0_F000;

   localparam word_t RST_CFG    = 32'h0080_0000;
   localparam word_t RST_RFSH   = 32'h05F0_0000;
   localparam word_t RST_PWR    = 32'h07C0_0000;

   localparam int NUM_ERR = 2;
   localparam int BIT_EN  = 31;
   localparam int BIT_SR  = 30;
endpackage

// File: rtl/memcfg_port_decode.sv
module memcfg_port_decode #(
   parameter int                PORT_W    = 10,
   parameter logic [PORT_W-1:0] PTR_PORT  = 'h010,
   parameter logic [PORT_W-1:0] WIN_PORT  = 'h011
) (
   input  logic [PORT_W-1:0] port,
   input  logic              wr,
   input  logic              rd,
   output logic              ptr_wr,
   output logic              win_wr,
   output logic              ptr_rd,
   output logic              win_rd
);
   logic hit_ptr, hit_win;

   assign hit_ptr = (port == PTR_PORT);
   assign hit_win = (port == WIN_PORT);
   assign ptr_wr  = wr && hit_ptr;
   assign win_wr  = wr && hit_win;
   assign ptr_rd  = rd && hit_ptr;
   assign win_rd  = rd && hit_win;
endmodule

// File: rtl/memcfg_w1c_reg.sv
module memcfg_w1c_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_we,
   input  logic [W-1:0] clr_bits,
   input  logic [W-1:0] set_bits,
   output logic [W-1:0] q
);
   logic [W-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_eff) | set_bits;
   end
endmodule

// File: rtl/memcfg_status_track.sv
module memcfg_status_track
   import memcfg_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cfg_we,
   input  word_t cfg_old,
   input  word_t cfg_new,
   output word_t status
);
   logic en_bit, sr_bit;

   // enable edges move status 31 in the opposite sense,
   // bit 30 edges move status 30 in the same sense
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_bit <= 1'b0;
         sr_bit <= 1'b0;
      end else if (cfg_we) begin
         if (!cfg_old[BIT_EN] && cfg_new[BIT_EN])      en_bit <= 1'b0;
         else if (cfg_old[BIT_EN] && !cfg_new[BIT_EN]) en_bit <= 1'b1;
         if (!cfg_old[BIT_SR] && cfg_new[BIT_SR])      sr_bit <= 1'b1;
         else if (cfg_old[BIT_SR] && !cfg_new[BIT_SR]) sr_bit <= 1'b0;
      end
   end

   always_comb begin
      status         = '0;
      status[BIT_EN] = en_bit;
      status[BIT_SR] = sr_bit;
   end
endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
   import memcfg_pkg::*;
#(
   parameter int                PORT_W   = 10,
   parameter int                DATA_W   = 32,
   parameter logic [PORT_W-1:0] PTR_PORT = 'h010,
   parameter logic [PORT_W-1:0] WIN_PORT = 'h011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] bus_port,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] err_set_a,
   input  logic [DATA_W-1:0] err_set_b,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ctrl_enable,
   output logic [DATA_W-1:0] cfg_word,
   output logic              ecc_irq
);
   // elaboration checks
   if (DATA_W != REG_W) begin : g_bad_width
      $error("memctl_cfg_regs: DATA_W must equal %0d", REG_W);
   end
   if (PTR_PORT == WIN_PORT) begin : g_bad_ports
      $error("memctl_cfg_regs: pointer and window ports must differ");
   end

   logic  ptr_wr, win_wr, ptr_rd, win_rd;
   word_t offset_q, eaddr_q, cfg_q, rfsh_q, pwr_q, ecfg_q, estat_q;
   word_t status_q, rd_word, rdata_q, win_word;
   word_t err_q   [NUM_ERR];
   word_t err_set [NUM_ERR];
   word_t err_ofs [NUM_ERR];

   memcfg_port_decode #(
      .PORT_W(PORT_W), .PTR_PORT(PTR_PORT), .WIN_PORT(WIN_PORT)
   ) u_dec (
      .port(bus_port), .wr(bus_wr), .rd(bus_rd),
      .ptr_wr(ptr_wr), .win_wr(win_wr), .ptr_rd(ptr_rd), .win_rd(win_rd)
   );

   assign err_set[0] = err_set_a;
   assign err_set[1] = err_set_b;
   assign err_ofs[0] = OFS_ERR_A;
   assign err_ofs[1] = OFS_ERR_B;

   for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
      memcfg_w1c_reg #(.W(REG_W)) u_err (
         .clk(clk), .rst_n(rst_n),
         .clr_we(win_wr && (offset_q == err_ofs[e])),
         .clr_bits(bus_wdata), .set_bits(err_set[e]), .q(err_q[e])
      );
   end

   memcfg_status_track u_stat (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(win_wr && (offset_q == OFS_CFG)),
      .cfg_old(cfg_q), .cfg_new(bus_wdata & MASK_CFG),
      .status(status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offset_q <= '0;
         eaddr_q  <= '0;
         cfg_q    <= RST_CFG;
         rfsh_q   <= RST_RFSH;
         pwr_q    <= RST_PWR;
         ecfg_q   <= '0;
         estat_q  <= '0;
      end else begin
         if (ptr_wr) offset_q <= bus_wdata;
         if (win_wr) begin
            case (offset_q)
               OFS_EADDR: eaddr_q <= bus_wdata;
               OFS_CFG:   cfg_q   <= bus_wdata & MASK_CFG;
               OFS_RFSH:  rfsh_q  <= bus_wdata & MASK_RFSH;
               OFS_PWR:   pwr_q   <= (bus_wdata & MASK_PWR) | FORCE_PWR;
               OFS_ECFG:  ecfg_q  <= bus_wdata & MASK_ECFG;
               OFS_ESTAT: estat_q <= bus_wdata & MASK_ESTAT;
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      case (offset_q)
         OFS_ERR_A: win_word = err_q[0];
         OFS_ERR_B: win_word = err_q[1];
         OFS_EADDR: win_word = eaddr_q;
         OFS_CFG:   win_word = cfg_q;
         OFS_STAT:  win_word = status_q;
         OFS_RFSH:  win_word = rfsh_q;
         OFS_PWR:   win_word = pwr_q;
         OFS_ECFG:  win_word = ecfg_q;
         OFS_ESTAT: win_word = estat_q;
         default:   win_word = '1;   // timing and unmapped offsets
      endcase
   end

   always_comb begin
      if (ptr_rd)      rd_word = offset_q;
      else if (win_rd) rd_word = win_word;
      else             rd_word = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_word;
   end

   assign bus_rdata   = rdata_q;
   assign cfg_word    = cfg_q;
   assign ctrl_enable = cfg_q[BIT_EN];
   assign ecc_irq     = (estat_q != '0);
endmodule

// File: rtl/memcfg_regs_chk.sv
module memcfg_regs_chk #(
   parameter int                PORT_W   = 10,
   parameter logic [PORT_W-1:0] PTR_PORT = 'h010,
   parameter logic [PORT_W-1:0] WIN_PORT = 'h011
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PORT_W-1:0] bus_port,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       err_set_a,
   input logic [31:0]       bus_rdata,
   input logic              ecc_irq,
   input logic [31:0]       offset_q,
   input logic [31:0]       cfg_q,
   input logic [31:0]       status_q,
   input logic [31:0]       err_a_q
);
   logic win_wr;
   assign win_wr = bus_wr && (bus_port == WIN_PORT);

   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   assert_ptr_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_port == PTR_PORT) |=> bus_rdata == $past(offset_q));

   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && offset_q == 32'h00 && err_set_a == '0)
      |=> (err_a_q & $past(bus_wdata)) == '0);

   assert_enable_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && offset_q == 32'h20 && !cfg_q[31] && bus_wdata[31])
      |=> !status_q[31]);

   assert_enable_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && offset_q == 32'h20 && cfg_q[31] && !bus_wdata[31])
      |=> status_q[31]);

   assert_status_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && offset_q == 32'h24) |=> $stable(status_q));

   assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && offset_q == 32'h98 && (bus_wdata & 32'hFFF0F000) != '0)
      |=> ecc_irq);
endmodule

bind memctl_cfg_regs memcfg_regs_chk #(
   .PORT_W(PORT_W), .PTR_PORT(PTR_PORT), .WIN_PORT(WIN_PORT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_port(bus_port), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_wdata(bus_wdata), .err_set_a(err_set_a),
   .bus_rdata(bus_rdata), .ecc_irq(ecc_irq), .offset_q(offset_q),
   .cfg_q(cfg_q), .status_q(status_q), .err_a_q(err_q[0])
);

// File: tb/test_memctl_cfg_regs.sv
`timescale 1ns/1ps
module test_memctl_cfg_regs;
   localparam logic [9:0] PTR = 10'h010;
   localparam logic [9:0] WIN = 10'h011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_port = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0, err_set_a = '0, err_set_b = '0;
   logic [31:0] bus_rdata, cfg_word;
   logic        ctrl_enable, ecc_irq;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   memctl_cfg_regs i_memctl_cfg_regs (
      .clk(clk), .rst_n(rst_n), .bus_port(bus_port), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .err_set_a(err_set_a),
      .err_set_b(err_set_b), .bus_rdata(bus_rdata),
      .ctrl_enable(ctrl_enable), .cfg_word(cfg_word), .ecc_irq(ecc_irq)
   );

   // {offset, write data, expected readback, requirement}
   localparam int NV = 15;
   localparam logic [31:0] VEC [0:NV-1][0:3] = '{
      '{32'h10, 32'h1234_5678, 32'h1234_5678, 4},   // R4
      '{32'h30, 32'hFFFF_FFFF, 32'h3FF8_0000, 9},   // R9
      '{32'h94, 32'hFFFF_FFFF, 32'h00F0_0000, 9},
      '{32'h34, 32'h0000_0000, 32'h07C0_0000, 9},
      '{32'h34, 32'hFFFF_FFFF, 32'hFFC0_0000, 9},
      '{32'h80, 32'h1234_5678, 32'hFFFF_FFFF, 11},  // R11
      '{32'h44, 32'h0000_0001, 32'hFFFF_FFFF, 11},
      '{32'h24, 32'hFFFF_FFFF, 32'h0000_0000, 8},   // R8
      '{32'h20, 32'hFFFF_FFFF, 32'hFFE0_0000, 5},   // R5
      '{32'h24, 32'h0000_0000, 32'h4000_0000, 7},   // R7 bit30 rose
      '{32'h20, 32'h0000_0000, 32'h0000_0000, 5},
      '{32'h24, 32'hFFFF_FFFF, 32'h8000_0000, 6},   // R6 bit31 fell, R7 bit30 fell
      '{32'h20, 32'h8000_0000, 32'h8000_0000, 5},
      '{32'h24, 32'h0000_0000, 32'h0000_0000, 6},   // R6 bit31 rose
      '{32'h98, 32'hFFFF_FFFF, 32'hFFF0_F000, 10}   // R10
   };

   localparam int NR = 10;
   localparam logic [31:0] RST [0:NR-1][0:1] = '{
      '{32'h00, 32'h0}, '{32'h08, 32'h0}, '{32'h10, 32'h0},
      '{32'h20, 32'h0080_0000}, '{32'h24, 32'h0},
      '{32'h30, 32'h05F0_0000}, '{32'h34, 32'h07C0_0000},
      '{32'h94, 32'h0}, '{32'h98, 32'h0}, '{32'h80, 32'hFFFF_FFFF}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [9:0] p, input logic [31:0] d);
      @(negedge clk);
      bus_port = p; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [9:0] p, output logic [31:0] d);
      @(negedge clk);
      bus_port = p; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd_reg(input logic [31:0] ofs, output logic [31:0] d);
      bus_write(PTR, ofs);
      bus_read(WIN, d);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got %08h expected %08h", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d, held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      chk("R12 enable", {31'b0, ctrl_enable}, 32'h0);
      chk("R12 cfg_word", cfg_word, 32'h0080_0000);
      chk("R12 irq", {31'b0, ecc_irq}, 32'h0);
      bus_read(PTR, d);
      chk("R12 offset", d, 32'h0);
      for (int i = 0; i < NR; i++) begin
         rd_reg(RST[i][0], d);
         chk("R12 reset value", d, RST[i][1]);
      end

      // R1 pointer readback
      bus_write(PTR, 32'hABCD_0123);
      bus_read(PTR, d);
      chk("R1 offset readback", d, 32'hABCD_0123);
      bus_read(WIN, d);
      chk("R11 wide unmapped offset", d, 32'hFFFF_FFFF);

      // R13 other port, R2 hold
      bus_read(10'h3FF, d);
      chk("R13 foreign port", d, 32'h0);
      bus_read(PTR, held);
      repeat (3) @(negedge clk);
      chk("R2 rdata hold", bus_rdata, held);

      // table walk
      for (int i = 0; i < NV; i++) begin
         bus_write(PTR, VEC[i][0]);
         bus_write(WIN, VEC[i][1]);
         bus_read(WIN, d);
         checks++;
         if (d !== VEC[i][2]) begin
            errors++;
            $display("FAIL R%0d vector %0d: got %08h expected %08h",
                     VEC[i][3], i, d, VEC[i][2]);
         end
      end
      chk("R5 ctrl_enable", {31'b0, ctrl_enable}, 32'h1);
      chk("R5 cfg_word", cfg_word, 32'h8000_0000);
      chk("R10 irq high", {31'b0, ecc_irq}, 32'h1);
      bus_write(PTR, 32'h98);
      bus_write(WIN, 32'h000F_0FFF);
      chk("R10 irq low after masked write", {31'b0, ecc_irq}, 32'h0);

      // R3 write-one-to-clear
      @(negedge clk); err_set_a = 32'h0000_00F0; err_set_b = 32'h0000_0F00;
      @(negedge clk); err_set_a = '0; err_set_b = '0;
      rd_reg(32'h00, d);
      chk("R3 set a", d, 32'h0000_00F0);
      bus_write(WIN, 32'h0000_0030);
      bus_read(WIN, d);
      chk("R3 clear a", d, 32'h0000_00C0);
      rd_reg(32'h08, d);
      chk("R3 b untouched", d, 32'h0000_0F00);
      @(negedge clk);
      bus_port = WIN; bus_wdata = 32'h0000_0F00; bus_wr = 1'b1; err_set_b = 32'h0000_0100;
      @(negedge clk);
      bus_wr = 1'b0; err_set_b = '0;
      bus_read(WIN, d);
      chk("R3 set wins", d, 32'h0000_0100);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule